// File: doc/BRIEF.md
# Dual-Output Serial Flash Fetch Controller

This block reads a run of bytes from a serial flash device using the dual-output fast read transaction. A client supplies a 24-bit start address and a byte count. The controller then returns the bytes in address order on a valid/ready stream. It handles one transaction at a time.

On the flash side the controller drives chip select, a mode-0 serial clock and one command/address line. It sends the opcode, the address and a dummy byte on that line. It then releases the line and gathers two bits per serial clock from two data lines.

The serial clock is made from the system clock by an integer divider. If the stream consumer stops accepting bytes, the controller parks the serial clock low between bytes, so no data is lost. The flash advances and wraps its own address, so one transaction can run for any count without sending the address again.

Top module: `flash_dual_fetch`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, the command line output enable is low, `out_valid` is low and `req_ready` is high.
- R2: When a request with a nonzero count is accepted, chip select goes low. `fl_io0_o` then carries the `OPCODE` parameter (default 0x3B) as 8 bits, then the 24-bit address, then 8 dummy bits, all most significant bit first. Each bit is stable at the rising serial clock edge that latches it.
- R3: The serial clock is low whenever chip select is high. While running, it is low for `DIV` system clocks and high for `DIV` system clocks.
- R4: `fl_io0_oe` is high from the fall of chip select through the 40 header clocks. It is low at every rising edge from serial clock 40 (counting from 0) onward.
- R5: Read data is sampled on rising edges starting with clock 40, four clocks per byte. The first clock of a byte gives bit 7 from `fl_io1_i` and bit 6 from `fl_io0_i`, the next gives bits 5 and 4, then bits 3 and 2, then bits 1 and 0.
- R6: Exactly `req_len` bytes are delivered, in order, within a single chip-select-low period of 40 + 4·`req_len` rising clocks. This includes a run that passes the top address and wraps to zero.
- R7: While `out_valid` is high and `out_ready` is low, `out_data` holds its value. The serial clock does not rise again until that byte is taken.
- R8: After the last byte, chip select returns high and stays high for at least `CS_GAP` system clocks before it falls again. `req_ready` is only high while chip select is high and no byte is pending.
- R9: A request with `req_len` equal to 0 is accepted without any chip select activity or output byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | 24 | Start byte address |
| req_len | input | LEN_W | Number of bytes to fetch |
| out_valid | output | 1 | Read byte available |
| out_ready | input | 1 | Consumer takes the byte |
| out_data | output | 8 | Read byte |
| fl_cs_n | output | 1 | Flash chip select, active low |
| fl_sck | output | 1 | Flash serial clock |
| fl_io0_o | output | 1 | Command/address/dummy bit out |
| fl_io0_oe | output | 1 | Output enable for data line 0 |
| fl_io0_i | input | 1 | Data line 0 in (even bits) |
| fl_io1_i | input | 1 | Data line 1 in (odd bits) |

## Verification
A behavioural flash model decodes the opcode and address. It drives a computed byte pattern that shifts on the falling serial clock edge. A start address two bytes below the top checks the wrap: a controller that reissued an address or stopped early would lose bytes or use a second chip-select period.

A consumer that takes bytes only every twentieth cycle checks the stall path. A design that kept clocking would overwrite held bytes, and the scoreboard would see them missing.

A zero-length request, back-to-back requests and a check of the number of rising edges catch three other faults: a design that still selects the flash, a chip-select gap that is too short, or a data window that is off by a clock.

// File: rtl/flash_dual_fetch.sv
module flash_dual_fetch #(
  parameter logic [7:0] OPCODE = 8'h3B,
  parameter int DIV    = 2,
  parameter int CS_GAP = 4,
  parameter int LEN_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [23:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             fl_cs_n,
  output logic             fl_sck,
  output logic             fl_io0_o,
  output logic             fl_io0_oe,
  input  logic             fl_io0_i,
  input  logic             fl_io1_i
);

  localparam int HDR_CLKS = 40;
  localparam int DIV_W    = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int GAP_W    = (CS_GAP > 1) ? $clog2(CS_GAP) : 1;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_GAP} st_t;

  st_t              st;
  logic [DIV_W-1:0] div_cnt;
  logic [GAP_W-1:0] gap_cnt;
  logic [39:0]      tx_sr;
  logic [5:0]       hdr_cnt;
  logic             data_ph;
  logic [1:0]       pair;
  logic [5:0]       rx_sr;
  logic [LEN_W-1:0] left;
  logic             tick, stall;

  assign tick      = div_cnt == DIV_W'(DIV - 1);
  assign stall     = data_ph && !fl_sck && pair == 2'd0 && out_valid && !out_ready;
  assign req_ready = st == S_IDLE && !out_valid;
  assign fl_io0_o  = tx_sr[39];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      fl_cs_n   <= 1'b1;
      fl_sck    <= 1'b0;
      fl_io0_oe <= 1'b0;
      tx_sr     <= '0;
      hdr_cnt   <= '0;
      data_ph   <= 1'b0;
      pair      <= '0;
      rx_sr     <= '0;
      left      <= '0;
      div_cnt   <= '0;
      gap_cnt   <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      case (st)
        S_IDLE: begin
          if (req_valid && req_ready && req_len != '0) begin
            st        <= S_RUN;
            fl_cs_n   <= 1'b0;
            fl_io0_oe <= 1'b1;
            tx_sr     <= {OPCODE, req_addr, 8'h00};
            hdr_cnt   <= '0;
            data_ph   <= 1'b0;
            pair      <= '0;
            left      <= req_len;
            div_cnt   <= '0;
          end
        end
        S_RUN: begin
          if (!tick) begin
            div_cnt <= div_cnt + 1'b1;
          end else if (!stall) begin
            div_cnt <= '0;
            if (!fl_sck) begin
              fl_sck <= 1'b1;
              if (data_ph) begin
                rx_sr <= {rx_sr[3:0], fl_io1_i, fl_io0_i};
                pair  <= pair + 1'b1;
                if (pair == 2'd3) begin
                  out_data  <= {rx_sr, fl_io1_i, fl_io0_i};
                  out_valid <= 1'b1;
                  left      <= left - 1'b1;
                end
              end
            end else begin
              fl_sck <= 1'b0;
              if (!data_ph) begin
                tx_sr   <= {tx_sr[38:0], 1'b0};
                hdr_cnt <= hdr_cnt + 1'b1;
                if (hdr_cnt == 6'(HDR_CLKS - 1)) begin
                  data_ph   <= 1'b1;
                  fl_io0_oe <= 1'b0;
                end
              end else if (pair == 2'd0 && left == '0) begin
                st      <= S_GAP;
                fl_cs_n <= 1'b1;
                gap_cnt <= '0;
              end
            end
          end
        end
        S_GAP: begin
          if (gap_cnt == GAP_W'(CS_GAP - 1)) st <= S_IDLE;
          else gap_cnt <= gap_cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/flash_dual_fetch_chk.sv
module flash_dual_fetch_chk #(
  parameter int CS_GAP = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       fl_cs_n,
  input logic       fl_sck,
  input logic       fl_io0_oe
);

  logic [31:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_cnt <= 32'(CS_GAP);
    else if (!fl_cs_n) hi_cnt <= '0;
    else if (hi_cnt < 32'(CS_GAP)) hi_cnt <= hi_cnt + 1'b1;
  end

  assert_idle_clk_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fl_cs_n |-> !fl_sck);

  assert_drive_at_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_cs_n) |-> fl_io0_oe);

  assert_hold_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  assert_park_clock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !fl_sck |=> !fl_sck);

  assert_cs_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_cs_n) |-> hi_cnt >= 32'(CS_GAP));

  assert_ready_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> fl_cs_n && !out_valid);

endmodule

bind flash_dual_fetch flash_dual_fetch_chk #(.CS_GAP(CS_GAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .fl_cs_n(fl_cs_n),
  .fl_sck(fl_sck), .fl_io0_oe(fl_io0_oe)
);

// File: tb/tb_flash_dual_fetch.sv
module tb_flash_dual_fetch;
  localparam int CS_GAP = 4;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, out_ready = 0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_len = '0;
  logic req_ready, out_valid, fl_cs_n, fl_sck, fl_io0_o, fl_io0_oe;
  logic [7:0] out_data;
  logic m_io0 = 0, m_io1 = 0;

  flash_dual_fetch #(.DIV(2), .CS_GAP(CS_GAP), .LEN_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .fl_cs_n(fl_cs_n),
    .fl_sck(fl_sck), .fl_io0_o(fl_io0_o), .fl_io0_oe(fl_io0_oe),
    .fl_io0_i(m_io0), .fl_io1_i(m_io1));

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  logic [7:0] expq[$];
  int rdy_mode = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rom(input logic [23:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'hA5;
  endfunction

  // flash model
  int rises = 0, cs_falls = 0, oe_bad = 0;
  logic [7:0] m_cmd = '0;
  logic [23:0] m_addr = '0;

  always @(negedge fl_cs_n) begin
    rises = 0;
    cs_falls++;
  end

  always @(posedge fl_sck) if (!fl_cs_n) begin
    if (rises < 8) m_cmd = {m_cmd[6:0], fl_io0_o};
    else if (rises < 32) m_addr = {m_addr[22:0], fl_io0_o};
    if ((rises < 40) != fl_io0_oe) oe_bad++;
    rises++;
  end

  always @(negedge fl_sck) if (!fl_cs_n && rises >= 40) begin : drv
    int d;
    logic [7:0] b;
    d = rises - 40;
    b = rom(m_addr + 24'(d / 4));
    m_io1 = b[7 - 2 * (d % 4)];
    m_io0 = b[6 - 2 * (d % 4)];
  end

  // monitor, consumer and protocol watch
  logic [15:0] lfsr = 16'hACE1;
  int slow = 0, hi = 0, idle_bad = 0, cyc = 0;
  bit seen_tx = 0, pv = 0, pr = 0;
  logic [7:0] pd = '0;

  always @(negedge clk) if (rst_n) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
    if (fl_cs_n && fl_sck) idle_bad++;
    if (fl_cs_n) hi++;
    else begin
      if (seen_tx && hi > 0) chk(hi >= CS_GAP, "R8 cs gap", hi, CS_GAP);
      if (hi > 0) seen_tx = 1;
      hi = 0;
    end
    if (pv && !pr) chk(out_valid && out_data == pd, "R7 hold", {out_valid, out_data}, {1'b1, pd});
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    slow = (slow + 1) % 20;
    case (rdy_mode)
      0: out_ready = 1;
      1: out_ready = lfsr[0];
      default: out_ready = (slow == 0);
    endcase
    if (out_valid && out_ready) begin
      if (expq.size() == 0) chk(0, "R6 unexpected byte", out_data, 0);
      else begin
        logic [7:0] e;
        e = expq.pop_front();
        chk(out_data == e, "R5/R6 byte", out_data, e);
      end
    end
    pv = out_valid;
    pr = out_ready;
    pd = out_data;
  end

  task automatic fetch(input logic [23:0] a, input int n, input int mode);
    int f0;
    rdy_mode = mode;
    for (int i = 0; i < n; i++) expq.push_back(rom(a + 24'(i)));
    do @(negedge clk); while (!req_ready);
    f0 = cs_falls;
    oe_bad = 0;
    req_valid = 1;
    req_addr = a;
    req_len = 16'(n);
    @(negedge clk);
    req_valid = 0;
    do @(negedge clk); while (expq.size() != 0 || !req_ready);
    repeat (2) @(negedge clk);
    if (n == 0) begin
      chk(cs_falls == f0, "R9 no select", cs_falls, f0);
    end else begin
      chk(cs_falls == f0 + 1, "R6 single select", cs_falls, f0 + 1);
      chk(m_cmd == 8'h3B, "R2 opcode", m_cmd, 8'h3B);
      chk(m_addr == a, "R2 address", m_addr, a);
      chk(rises == 40 + 4 * n, "R5 clock count", rises, 40 + 4 * n);
      chk(oe_bad == 0, "R4 line release", oe_bad, 0);
    end
    chk(idle_bad == 0, "R3 idle clock", idle_bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(fl_cs_n == 1, "R1 cs", fl_cs_n, 1);
    chk(fl_sck == 0, "R1 sck", fl_sck, 0);
    chk(fl_io0_oe == 0, "R1 oe", fl_io0_oe, 0);
    chk(out_valid == 0, "R1 valid", out_valid, 0);
    chk(req_ready == 1, "R1 ready", req_ready, 1);
    fetch(24'h000100, 6, 0);
    fetch(24'h12ABCD, 9, 1);
    fetch(24'hFFFFFE, 5, 0);
    fetch(24'h000003, 0, 0);
    fetch(24'h0F0F0F, 4, 2);
    fetch(24'h800000, 16, 1);
    fetch(24'h3C5A7E, 3, 2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule